// File: doc/BRIEF.md
# LCD Common Scan Timing Generator

This block produces the row-scan timing for a character dot-matrix liquid crystal panel, running from a slow oscillator clock of roughly 270 kHz. It walks through the active common lines one row at a time. For each row it gives one common-select line, a row index, a latch pulse for the segment data (`cl1`), a serial shift clock for the segment bits (`cl2`) and a drive-polarity signal (`m_out`).

Two configuration inputs choose the duty mode:

- **1/8 duty**: one text line with the short font. Commons 0 to 7 are scanned.
- **1/11 duty**: one text line with the tall font. Commons 0 to 10 are scanned.
- **1/16 duty**: two text lines. Commons 0 to 15 are scanned and the font input has no effect.

A row in the 1/16 mode lasts half as many clocks as a row in the other two modes. This keeps the 1/8 and 1/16 frame periods equal. The 1/11 frame is longer, by the ratio of its row count to 8.

Segment handling within a row works as follows:

- Bits for the following row are shifted out on `cl2` while the current row is lit.
- They are latched on the single-clock `cl1` pulse that opens the next row.

The drive polarity `m_out` flips once per complete frame. A change on the configuration inputs is held off until the next frame boundary, so a frame never mixes two duty modes.

Top module: `lcd_com_scan`

## Requirements
- R1: On synchronous reset (`rst` high at a clock edge), the block samples the configuration inputs. In the first cycle after reset: `row_idx` is 0, `com_sel` is 16'h0001, `m_out` is 0 and `cl1` is 1.
- R2: With `two_line`=0 and `tall_font`=0, `row_idx` counts 0,1,…,7 and then returns to 0.
- R3: With `two_line`=0 and `tall_font`=1, `row_idx` counts 0,1,…,10 and then returns to 0.
- R4: With `two_line`=1, `row_idx` counts 0,1,…,15 and then returns to 0, whatever the value of `tall_font`.
- R5: Row length depends on the duty mode:
  - In the 1/8 and 1/11 modes each row lasts ROW_WIDE clocks (default 400).
  - In the 1/16 mode each row lasts ROW_NARROW clocks (default 200).
- R6: `com_sel` is one-hot, with bit `row_idx` set. Bit k is 1 only while `row_idx` equals k, so commons above the last active row stay 0.
- R7: `cl1` is high for exactly one clock: the first clock of every row (row offset 0).
- R8: `cl2` gives SEG_BITS single-clock pulses per row, at row offsets 1, 3, …, 2·SEG_BITS−1. It is low at every other offset and is never high together with `cl1`.
- R9: `m_out` inverts exactly on the clock where `row_idx` wraps from the last active row to 0. At all other times it holds its value.
- R10: A change of `two_line` or `tall_font` in the middle of a frame has no effect on row count or row length until the next wrap to row 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| two_line | input | 1 | 1 selects two-line display (1/16 duty) |
| tall_font | input | 1 | 1 selects tall font in one-line mode (1/11 duty) |
| com_sel | output | 16 | One-hot common-select vector |
| row_idx | output | 4 | Index of the common being driven |
| cl1 | output | 1 | Segment latch pulse, first clock of each row |
| cl2 | output | 1 | Segment serial shift clock |
| m_out | output | 1 | Drive polarity, flips once per frame |

## Verification
The bench builds the block with ROW_WIDE=20, ROW_NARROW=12 and SEG_BITS=4, in place of 400, 200 and 40. Every clock of every frame can then be compared against the expected row index, select vector, latch and shift pattern within a few thousand cycles. These short rows still leave idle clocks after the last shift pulse. They also keep the two row lengths distinct, so a wrong length choice or a premature mode switch shows up within one row. Frames in all three duty modes are checked, along with configuration changes at frame start and a reset in the middle of a frame.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

    localparam int COM_COUNT = 16;
    localparam int ROW_W     = $clog2(COM_COUNT);

    typedef enum logic [1:0] {
        DUTY_8  = 2'd0,
        DUTY_11 = 2'd1,
        DUTY_16 = 2'd2
    } duty_e;

    typedef struct packed {
        logic [ROW_W-1:0] row;
        logic             pol;
        duty_e            duty;
    } scan_state_t;

    function automatic duty_e pick_duty(input logic two_line, input logic tall_font);
        if (two_line)
            return DUTY_16;
        else if (tall_font)
            return DUTY_11;
        else
            return DUTY_8;
    endfunction

    function automatic logic [ROW_W-1:0] final_row(input duty_e d);
        case (d)
            DUTY_11: return ROW_W'(10);
            DUTY_16: return ROW_W'(15);
            default: return ROW_W'(7);
        endcase
    endfunction

    function automatic logic short_rows(input duty_e d);
        return d == DUTY_16;
    endfunction

endpackage

// File: rtl/lcd_row_timer.sv
module lcd_row_timer
    import lcd_scan_pkg::*;
#(
    parameter int ROW_WIDE   = 400,
    parameter int ROW_NARROW = 200,
    parameter int SEG_BITS   = 40
) (
    input  logic clk,
    input  logic rst,
    input  logic narrow,
    output logic row_end,
    output logic cl1,
    output logic cl2
);

    localparam int MAX_LEN  = (ROW_WIDE > ROW_NARROW) ? ROW_WIDE : ROW_NARROW;
    localparam int TICK_W   = (MAX_LEN > 2) ? $clog2(MAX_LEN) : 1;
    localparam int SHIFT_END = 2 * SEG_BITS;
    localparam logic [TICK_W-1:0] LAST_WIDE   = TICK_W'(ROW_WIDE - 1);
    localparam logic [TICK_W-1:0] LAST_NARROW = TICK_W'(ROW_NARROW - 1);

    logic [TICK_W-1:0] tick;

    always_ff @(posedge clk) begin
        if (rst)
            tick <= '0;
        else if (row_end)
            tick <= '0;
        else
            tick <= tick + 1'b1;
    end

    always_comb begin
        row_end = (tick == (narrow ? LAST_NARROW : LAST_WIDE));
        cl1     = (tick == '0);
        cl2     = tick[0] && (int'(tick) < SHIFT_END);
    end

endmodule

// File: rtl/lcd_row_stepper.sv
module lcd_row_stepper
    import lcd_scan_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             two_line,
    input  logic             tall_font,
    input  logic             row_end,
    output logic [ROW_W-1:0] row_idx,
    output logic             pol,
    output duty_e            duty
);

    scan_state_t st;
    logic        at_last;

    assign at_last = (st.row == final_row(st.duty));

    always_ff @(posedge clk) begin
        if (rst) begin
            st.row  <= '0;
            st.pol  <= 1'b0;
            st.duty <= pick_duty(two_line, tall_font);
        end else if (row_end) begin
            if (at_last) begin
                st.row  <= '0;
                st.pol  <= ~st.pol;
                st.duty <= pick_duty(two_line, tall_font);
            end else begin
                st.row  <= st.row + 1'b1;
            end
        end
    end

    assign row_idx = st.row;
    assign pol     = st.pol;
    assign duty    = st.duty;

endmodule

// File: rtl/lcd_com_decoder.sv
module lcd_com_decoder
    import lcd_scan_pkg::*;
(
    input  logic [ROW_W-1:0]     row_idx,
    output logic [COM_COUNT-1:0] com_sel
);

    for (genvar g = 0; g < COM_COUNT; g++) begin : g_com
        assign com_sel[g] = (row_idx == ROW_W'(g));
    end

endmodule

// File: rtl/lcd_com_scan.sv
module lcd_com_scan
    import lcd_scan_pkg::*;
#(
    parameter int ROW_WIDE   = 400,
    parameter int ROW_NARROW = 200,
    parameter int SEG_BITS   = 40
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        two_line,
    input  logic        tall_font,
    output logic [15:0] com_sel,
    output logic [3:0]  row_idx,
    output logic        cl1,
    output logic        cl2,
    output logic        m_out
);

    duty_e active_duty;
    logic  row_end;

    lcd_row_timer #(
        .ROW_WIDE  (ROW_WIDE),
        .ROW_NARROW(ROW_NARROW),
        .SEG_BITS  (SEG_BITS)
    ) i_timer (
        .clk    (clk),
        .rst    (rst),
        .narrow (short_rows(active_duty)),
        .row_end(row_end),
        .cl1    (cl1),
        .cl2    (cl2)
    );

    lcd_row_stepper i_stepper (
        .clk      (clk),
        .rst      (rst),
        .two_line (two_line),
        .tall_font(tall_font),
        .row_end  (row_end),
        .row_idx  (row_idx),
        .pol      (m_out),
        .duty     (active_duty)
    );

    lcd_com_decoder i_decoder (
        .row_idx(row_idx),
        .com_sel(com_sel)
    );

endmodule

// File: rtl/lcd_com_scan_chk.sv
module lcd_com_scan_chk
    import lcd_scan_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic [15:0] com_sel,
    input logic [3:0]  row_idx,
    input logic        cl1,
    input logic        cl2,
    input logic        m_out,
    input logic [1:0]  duty
);

    assert_onehot_R6: assert property (@(posedge clk) disable iff (rst)
        $countones(com_sel) == 1);

    assert_active_range_R6: assert property (@(posedge clk) disable iff (rst)
        row_idx <= final_row(duty_e'(duty)));

    assert_row_moves_on_latch_R2: assert property (@(posedge clk) disable iff (rst)
        !$stable(row_idx) |-> cl1);

    assert_latch_single_R7: assert property (@(posedge clk) disable iff (rst)
        cl1 |=> !cl1);

    assert_shift_gap_R8: assert property (@(posedge clk) disable iff (rst)
        cl2 |=> !cl2);

    assert_shift_not_latch_R8: assert property (@(posedge clk) disable iff (rst)
        !(cl1 && cl2));

    assert_pol_at_wrap_R9: assert property (@(posedge clk) disable iff (rst)
        !$stable(m_out) |-> (row_idx == 4'd0 && cl1));

    assert_mode_at_wrap_R10: assert property (@(posedge clk) disable iff (rst)
        !$stable(duty) |-> (row_idx == 4'd0 && cl1));

endmodule

bind lcd_com_scan lcd_com_scan_chk i_chk (
    .clk    (clk),
    .rst    (rst),
    .com_sel(com_sel),
    .row_idx(row_idx),
    .cl1    (cl1),
    .cl2    (cl2),
    .m_out  (m_out),
    .duty   (active_duty)
);

// File: tb/test_lcd_com_scan.sv
module test_lcd_com_scan;

    localparam int WIDE   = 20;
    localparam int NARROW = 12;
    localparam int SEG    = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        two_line = 1'b0;
    logic        tall_font = 1'b0;
    logic [15:0] com_sel;
    logic [3:0]  row_idx;
    logic        cl1, cl2, m_out;

    int   errors = 0;
    int   checks = 0;
    logic exp_m  = 1'b0;

    always #2 clk = ~clk;

    lcd_com_scan #(
        .ROW_WIDE  (WIDE),
        .ROW_NARROW(NARROW),
        .SEG_BITS  (SEG)
    ) i_lcd_com_scan (
        .clk      (clk),
        .rst      (rst),
        .two_line (two_line),
        .tall_font(tall_font),
        .com_sel  (com_sel),
        .row_idx  (row_idx),
        .cl1      (cl1),
        .cl2      (cl2),
        .m_out    (m_out)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Walks one frame from row 0 offset 0, sampling at falling edges.
    task automatic run_frame(input int last, input int len, input string req);
        for (int r = 0; r <= last; r++) begin
            for (int t = 0; t < len; t++) begin
                chk(row_idx == 4'(r), req, int'(row_idx), r);
                chk(com_sel == 16'(1 << r), "R6 select", int'(com_sel), 1 << r);
                chk(cl1 == (t == 0), "R7 latch", int'(cl1), int'(t == 0));
                chk(cl2 == ((t % 2 == 1) && (t < 2 * SEG)), "R8 shift",
                    int'(cl2), int'((t % 2 == 1) && (t < 2 * SEG)));
                chk(m_out == exp_m, "R9 polarity", int'(m_out), int'(exp_m));
                @(negedge clk);
            end
        end
        exp_m = ~exp_m;
    endtask

    task automatic do_reset(input logic n, input logic f);
        rst       = 1'b1;
        two_line  = n;
        tall_font = f;
        repeat (3) @(negedge clk);
        rst   = 1'b0;
        exp_m = 1'b0;
        chk(row_idx == 4'd0, "R1 row", int'(row_idx), 0);
        chk(com_sel == 16'h0001, "R1 select", int'(com_sel), 1);
        chk(m_out == 1'b0, "R1 polarity", int'(m_out), 0);
        chk(cl1 == 1'b1, "R1 latch", int'(cl1), 1);
    endtask

    task automatic t_short_font;
        do_reset(1'b0, 1'b0);
        run_frame(7, WIDE, "R2/R5 eight rows");
        run_frame(7, WIDE, "R2/R5 eight rows again");
    endtask

    task automatic t_tall_font;
        tall_font = 1'b1;
        run_frame(7, WIDE, "R10 old mode held");
        run_frame(10, WIDE, "R3/R5 eleven rows");
    endtask

    task automatic t_two_line;
        two_line = 1'b1;
        run_frame(10, WIDE, "R10 old mode held");
        run_frame(15, NARROW, "R4/R5 sixteen short rows");
        tall_font = 1'b0;
        run_frame(15, NARROW, "R4 font ignored");
    endtask

    task automatic t_midrun_reset;
        repeat (5) @(negedge clk);
        do_reset(1'b0, 1'b1);
        run_frame(10, WIDE, "R1/R3 mode sampled at reset");
        tall_font = 1'b0;
        run_frame(10, WIDE, "R10 old mode held");
        run_frame(7, WIDE, "R2 back to eight rows");
    endtask

    initial begin
        @(negedge clk);
        t_short_font();
        t_tall_font();
        t_two_line();
        t_midrun_reset();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule